// File: doc/BRIEF.md
# Dual-Domain Display Interrupt Controller

This block collects up to 49 event lines from a display pipeline and turns each into its own level interrupt line. The sources are held in two 32-bit banks: source `s` lives in bank `s/32`, bit `s%32`. Every source is steered by a per-bit route-select register to one of two independent register domains, a system domain and a user domain. Each domain has its own enable, set (preset), acknowledge (clear) and pending (status) registers. A source's output line is high when the pending bit and the enable bit of its chosen domain are both set.

Software reaches the registers through a simple word-wide port. A write strobe commits `wdata` at the addressed offset on a clock edge. `rdata` is a combinational view of the addressed offset. Software masks a source by clearing its enable bit. It acknowledges the source by writing a one to its bit in the clear register of its domain. Source 35 and all bank-1 bits from 17 upward do not exist in hardware.

Top module: `dispirq_ctrl`

## Requirements
- R1: After reset, every route-select, enable and pending bit is 0, every readable offset returns 0 and all `irq_o` lines are low.
- R2: A pending bit is set by a 0-to-1 transition of its source, sampled on `clk`. The bit is set only in the domain that the source's route-select bit picks (1 = user, 0 = system), and it is visible one edge after the source is first sampled high. A source held high does not set the bit again after it is cleared.
- R3: Writing a word to a preset offset sets the pending bits where the word has ones. Zero bits leave pending bits unchanged.
- R4: Writing a word to a clear offset clears the pending bits where the word has ones. Zero bits leave pending bits unchanged.
- R5: When a source edge and a clear of the same bit fall in the same cycle, the pending bit ends up set.
- R6: `irq_o[s]` equals pending AND enable of the domain that route-select bit `s` picks. Changing the route-select bit re-steers the output at once, with no new event needed.
- R7: Bank-1 bits in 0xFFFE0008 are not implemented (source 35 and sources 49 to 63). They read 0 in every register and ignore writes, and `irq_o[35]` stays low.
- R8: Preset and clear offsets read 0. Writes to status offsets and unmapped offsets are ignored, and unmapped offsets read 0.
- R9: Route-select and enable registers read back the implemented bits that were last written.
- R10: Byte offsets for bank n (n = 0 or 1) are: route-select 0x08+4n; system enable 0x10+4n, preset 0x18+4n, clear 0x20+4n, status 0x28+4n; user enable 0x40+4n, preset 0x48+4n, clear 0x50+4n, status 0x58+4n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 49 | Event source lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq_o | output | 49 | Per-source interrupt lines |

## Verification
A source can rise in the same cycle that software writes that source's bit to a clear register. The bench provokes this by raising the source line and presenting the clear write in the same low clock phase. After the edge it reads the status offset and expects the bit to be set, because a fresh event must not be lost to a late acknowledge. The companion case is a clear of a source that is still held high with no new edge. There the bit must stay cleared, which shows that the set comes from the edge and not from the level.

// File: rtl/dispirq_pkg.sv
package dispirq_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    FN_NONE,
    FN_ROUTE,
    FN_EN,
    FN_SET,
    FN_CLR,
    FN_PEND
  } fn_e;

  typedef struct packed {
    fn_e  fn;
    logic dom;   // 0 system, 1 user
    logic bank;
  } dec_t;

  // Implemented bits of one bank
  function automatic logic [WORD_W-1:0] impl_bits(input int bank, input int nsrc, input int rsvd);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_W; i++) begin
      m[i] = ((bank * WORD_W + i) < nsrc) && ((bank * WORD_W + i) != rsvd);
    end
    return m;
  endfunction

  // Offset decode (R10)
  function automatic dec_t decode(input logic [7:0] a);
    dec_t d;
    d.fn   = FN_NONE;
    d.dom  = 1'b0;
    d.bank = a[2];
    if (a[1:0] == 2'b00) begin
      case (a[7:3])
        5'd1:  d.fn = FN_ROUTE;
        5'd2:  d.fn = FN_EN;
        5'd3:  d.fn = FN_SET;
        5'd4:  d.fn = FN_CLR;
        5'd5:  d.fn = FN_PEND;
        5'd8:  begin d.fn = FN_EN;   d.dom = 1'b1; end
        5'd9:  begin d.fn = FN_SET;  d.dom = 1'b1; end
        5'd10: begin d.fn = FN_CLR;  d.dom = 1'b1; end
        5'd11: begin d.fn = FN_PEND; d.dom = 1'b1; end
        default: d.fn = FN_NONE;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/dispirq_domain.sv
module dispirq_domain
  import dispirq_pkg::*;
#(
  parameter logic [WORD_W-1:0] IMPL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] set_evt,
  input  logic              en_we,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] en_q,
  output logic [WORD_W-1:0] pend_q
);

  logic [WORD_W-1:0] en_d, pend_d, set_bits, clr_bits;

  always_comb begin
    set_bits = (set_evt | (set_we ? wdata : '0)) & IMPL;
    clr_bits = clr_we ? wdata : '0;
    pend_d   = ((pend_q & ~clr_bits) | set_bits) & IMPL;
    en_d     = en_we ? (wdata & IMPL) : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_we) en_q <= en_d;
      pend_q <= pend_d;
    end
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((pend_q & $past(wdata & IMPL)) == $past(wdata & IMPL))); // R3

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((pend_q & $past(wdata & ~set_evt)) == '0)); // R4

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && ((set_evt & wdata) != '0)) |=>
      ((pend_q & $past(set_evt & wdata)) == $past(set_evt & wdata))); // R5

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we && (set_evt == '0)) |=> $stable(pend_q)); // R2

endmodule

// File: rtl/dispirq_bank.sv
module dispirq_bank
  import dispirq_pkg::*;
#(
  parameter int BANK = 0,
  parameter logic [WORD_W-1:0] IMPL = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [WORD_W-1:0]      src,
  input  logic                   wr_en,
  input  dec_t                   dec,
  input  logic [WORD_W-1:0]      wdata,
  output logic [WORD_W-1:0]      route_q,
  output logic [1:0][WORD_W-1:0] en_q,
  output logic [1:0][WORD_W-1:0] pend_q,
  output logic [WORD_W-1:0]      irq
);

  logic              sel;
  logic              route_we;
  logic [WORD_W-1:0] src_q, src_d, route_d, rise;

  assign sel      = wr_en && (int'(dec.bank) == BANK);
  assign route_we = sel && (dec.fn == FN_ROUTE);

  always_comb begin
    src_d   = src & IMPL;
    rise    = src_d & ~src_q;
    route_d = route_we ? (wdata & IMPL) : route_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      route_q <= '0;
    end else begin
      src_q <= src_d;
      if (route_we) route_q <= route_d;
    end
  end

  for (genvar d = 0; d < 2; d++) begin : g_dom
    logic [WORD_W-1:0] steer;
    assign steer = (d == 1) ? route_q : ~route_q;
    dispirq_domain #(.IMPL(IMPL)) u_dom (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_evt(rise & steer),
      .en_we  (sel && (dec.fn == FN_EN)  && (int'(dec.dom) == d)),
      .set_we (sel && (dec.fn == FN_SET) && (int'(dec.dom) == d)),
      .clr_we (sel && (dec.fn == FN_CLR) && (int'(dec.dom) == d)),
      .wdata  (wdata),
      .en_q   (en_q[d]),
      .pend_q (pend_q[d])
    );
  end

  always_comb begin
    irq = ((pend_q[1] & en_q[1] & route_q) | (pend_q[0] & en_q[0] & ~route_q)) & IMPL;
  end

endmodule

// File: rtl/dispirq_ctrl.sv
module dispirq_ctrl
  import dispirq_pkg::*;
#(
  parameter int NUM_SRC  = 49,
  parameter int RSVD_SRC = 35
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en,
  input  logic [7:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic [NUM_SRC-1:0] irq_o
);

  localparam int NBANK = (NUM_SRC + WORD_W - 1) / WORD_W;
  localparam int PAD_W = NBANK * WORD_W;

  dec_t                               dec;
  logic [PAD_W-1:0]                   src_pad, irq_pad;
  logic [NBANK-1:0][WORD_W-1:0]       route_q;
  logic [NBANK-1:0][1:0][WORD_W-1:0]  en_q, pend_q;

  assign dec     = decode(addr);
  assign src_pad = PAD_W'(src_i);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dispirq_bank #(
      .BANK(b),
      .IMPL(impl_bits(b, NUM_SRC, RSVD_SRC))
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (src_pad[b*WORD_W +: WORD_W]),
      .wr_en  (wr_en),
      .dec    (dec),
      .wdata  (wdata),
      .route_q(route_q[b]),
      .en_q   (en_q[b]),
      .pend_q (pend_q[b]),
      .irq    (irq_pad[b*WORD_W +: WORD_W])
    );
  end

  always_comb begin
    rdata = '0;
    if (int'(dec.bank) < NBANK) begin
      case (dec.fn)
        FN_ROUTE: rdata = route_q[dec.bank];
        FN_EN:    rdata = en_q[dec.bank][dec.dom];
        FN_PEND:  rdata = pend_q[dec.bank][dec.dom];
        default:  rdata = '0;
      endcase
    end
  end

  assign irq_o = irq_pad[NUM_SRC-1:0];

  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[RSVD_SRC] == 1'b0); // R7

  AST_WO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((dec.fn == FN_SET) || (dec.fn == FN_CLR) || (dec.fn == FN_NONE)) |-> (rdata == '0)); // R8

endmodule

// File: tb/dispirq_ctrl_tb.sv
module dispirq_ctrl_tb;

  localparam int NS = 49;

  localparam logic [7:0] A_ROUTE0 = 8'h08, A_ROUTE1 = 8'h0C;
  localparam logic [7:0] A_EN0    = 8'h10, A_EN1    = 8'h14;
  localparam logic [7:0] A_SET0   = 8'h18, A_SET1   = 8'h1C;
  localparam logic [7:0] A_CLR0   = 8'h20, A_CLR1   = 8'h24;
  localparam logic [7:0] A_PND0   = 8'h28, A_PND1   = 8'h2C;
  localparam logic [7:0] A_UEN0   = 8'h40, A_UEN1   = 8'h44;
  localparam logic [7:0] A_USET0  = 8'h48;
  localparam logic [7:0] A_UCLR0  = 8'h50, A_UCLR1  = 8'h54;
  localparam logic [7:0] A_UPND0  = 8'h58, A_UPND1  = 8'h5C;
  localparam logic [31:0] IMPL1   = 32'h0001FFF7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src_i;
  logic          wr_en;
  logic [7:0]    addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic [NS-1:0] irq_o;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dispirq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, 64'(rdata), 64'(exp));
  endtask

  task automatic pulse(input int s);
    @(negedge clk); src_i[s] = 1'b1;
    @(negedge clk); src_i[s] = 1'b0;
  endtask

  task automatic t_reset();
    rd("R1 route0", A_ROUTE0, 0); rd("R1 en1", A_EN1, 0);
    rd("R1 pend0", A_PND0, 0);    rd("R1 upend1", A_UPND1, 0);
    rd("R1 uen0", A_UEN0, 0);
    chk("R1 irq", 64'(irq_o), 0);
  endtask

  task automatic t_readback();
    wr(A_ROUTE0, 32'hA5A5_5A5A); rd("R9 route0", A_ROUTE0, 32'hA5A5_5A5A);
    wr(A_EN0, 32'hFFFF_FFFF);    rd("R9 en0", A_EN0, 32'hFFFF_FFFF);
    wr(A_UEN1, 32'hFFFF_FFFF);   rd("R7 uen1 unimpl", A_UEN1, IMPL1);
    wr(A_ROUTE1, 32'hFFFF_FFFF); rd("R7 route1 unimpl", A_ROUTE1, IMPL1);
    wr(A_ROUTE0, 0); wr(A_EN0, 0); wr(A_UEN1, 0); wr(A_ROUTE1, 0);
    rd("R9 route0 cleared", A_ROUTE0, 0);
  endtask

  task automatic t_edge_sys();
    wr(A_EN0, 32'h20);
    pulse(5);
    rd("R2 sys pend", A_PND0, 32'h20);
    rd("R2 user untouched", A_UPND0, 0);
    chk("R6 irq5 high", 64'(irq_o[5]), 1);
    wr(A_CLR0, 32'h0);
    rd("R4 zero clear no effect", A_PND0, 32'h20);
    wr(A_CLR0, 32'h20);
    rd("R4 clear", A_PND0, 0);
    chk("R6 irq5 low", 64'(irq_o[5]), 0);
    // held high: one edge, clear, no re-arm
    @(negedge clk); src_i[5] = 1'b1;
    @(negedge clk);
    rd("R2 level edge", A_PND0, 32'h20);
    wr(A_CLR0, 32'h20);
    repeat (3) @(negedge clk);
    rd("R2 held level no reset", A_PND0, 0);
    src_i[5] = 1'b0;
    wr(A_EN0, 0);
  endtask

  task automatic t_user();
    wr(A_ROUTE1, 32'h1);
    wr(A_UEN1, 32'h1);
    pulse(32);
    rd("R2 user pend", A_UPND1, 32'h1);
    rd("R2 sys untouched", A_PND1, 0);
    chk("R6 irq32 user", 64'(irq_o[32]), 1);
    wr(A_ROUTE1, 32'h0);
    chk("R6 reroute drops", 64'(irq_o[32]), 0);
    wr(A_ROUTE1, 32'h1);
    chk("R6 reroute restores", 64'(irq_o[32]), 1);
    wr(A_UCLR1, 32'h1);
    rd("R4 user clear", A_UPND1, 0);
    wr(A_ROUTE1, 0); wr(A_UEN1, 0);
  endtask

  task automatic t_preset_map();
    wr(A_SET0, 32'h0);
    rd("R3 zero preset", A_PND0, 0);
    wr(A_EN0, 32'h1);
    wr(A_SET0, 32'h81);
    rd("R3 preset", A_PND0, 32'h81);
    chk("R6 irq0", 64'(irq_o[0]), 1);
    chk("R6 irq7 disabled", 64'(irq_o[7]), 0);
    wr(A_USET0, 32'h4);
    rd("R3 user preset", A_UPND0, 32'h4);
    rd("R8 preset reads 0", A_SET0, 0);
    rd("R8 clear reads 0", A_UCLR0, 0);
    wr(A_PND0, 32'hFFFF_FFFF);
    rd("R8 status write ignored", A_PND0, 32'h81);
    wr(8'h30, 32'hFFFF_FFFF);
    rd("R8 unmapped 30", 8'h30, 0);
    rd("R8 unmapped 00", 8'h00, 0);
    rd("R8 misaligned", 8'h11, 0);
    rd("R8 pend after unmapped write", A_PND0, 32'h81);
    wr(A_CLR0, 32'hFFFF_FFFF); wr(A_UCLR0, 32'hFFFF_FFFF); wr(A_EN0, 0);
    rd("R4 all cleared", A_PND0, 0);
  endtask

  task automatic t_race();
    @(negedge clk);
    src_i[7] = 1'b1; wr_en = 1'b1; addr = A_CLR0; wdata = 32'h80;
    @(negedge clk);
    wr_en = 1'b0; src_i[7] = 1'b0;
    rd("R5 event beats clear", A_PND0, 32'h80);
    wr(A_CLR0, 32'h80);
    rd("R5 later clear", A_PND0, 0);
  endtask

  task automatic t_rsvd();
    wr(A_EN1, 32'hFFFF_FFFF);
    pulse(35);
    rd("R7 src35 no status", A_PND1, 0);
    chk("R7 irq35", 64'(irq_o[35]), 0);
    wr(A_SET1, 32'hFFFF_FFFF);
    rd("R7 preset unimpl", A_PND1, IMPL1);
    chk("R7 irq35 after preset", 64'(irq_o[35]), 0);
    chk("R6 irq48", 64'(irq_o[48]), 1);
    wr(A_CLR1, 32'hFFFF_FFFF); wr(A_EN1, 0);
  endtask

  initial begin
    rst_n = 1'b0; src_i = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_edge_sys();
    t_user();
    t_preset_map();
    t_race();
    t_rsvd();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule